// File: doc/BRIEF.md
# Synthesizer Divider Configuration Controller

This block owns the divider settings of a clock synthesizer. It drives the feedback divider M (10 bits), the post-dividers NA (3 bits) and NB (1 bit), and the pre-divider P (1 bit). A byte-wide register bus reaches it with an address, write data, a write strobe, a read strobe and combinational read data. Two shadow registers hold a staged configuration. A write-only command port acts on the live divider state.

The live dividers and the shadow registers are separate storage. In serial mode (`serial_mode` high) software writes the shadow registers and then issues a load command to move them into the live dividers. Increment and decrement commands step only the live M. A capture command copies the live state back into the shadows. In parallel mode (`serial_mode` low) the configuration pins drive the dividers directly, reads return the pin configuration, and all bus writes are ignored.

Top module: `synth_div_ctrl`

## Requirements
- R1: On a clock edge with `rst_n` low, the live dividers and both shadow registers clear to zero. In serial mode, after reset, the divider outputs are 0 and register reads return 0 apart from the lock bit.
- R2: Address 0x00 is the low M register, M[7:0]. In serial mode it reads back the last value written to it.
- R3: Address 0x01 reads as {M[9:8], NA[2:0], NB, P, lock}, from bit 7 down to bit 0. Bit 0 always reflects `pll_locked`, and writes to bit 0 have no effect.
- R4: Writing a byte whose low nibble is 0x4 to address 0xF0 is the load command. At the next edge it copies both shadow registers into the live dividers, whatever the upper nibble holds. A shadow register write alone leaves the dividers unchanged.
- R5: Low nibble 0x1 at address 0xF0 adds 1 to the live M, and 0x2 subtracts 1, effective at the next edge. Both leave the shadow registers unchanged.
- R6: M wraps modulo 1024: incrementing from 1023 gives 0, and decrementing from 0 gives 1023.
- R7: Low nibble 0x8 at address 0xF0 is the capture command. At the next edge it copies the live M, NA, NB and P into the shadow registers.
- R8: A command byte whose low nibble is not exactly 0x1, 0x2, 0x4 or 0x8 changes nothing.
- R9: In parallel mode the dividers equal the pins in the same cycle, reads of 0x00 and 0x01 return the pin configuration, and writes to any address (commands included) change neither the dividers nor the read values.
- R10: On a change from parallel to serial, the dividers and registers keep the last pin configuration. On a change from serial to parallel, the dividers take the pin values at once.
- R11: A read of 0xF0 or of any unmapped address returns 0x00, and `bus_rdata` is 0x00 while `bus_rd` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_addr | input | 8 | Register address |
| bus_wdata | input | 8 | Write data |
| bus_wr | input | 1 | Write strobe, acts on the clock edge |
| bus_rd | input | 1 | Read strobe, gates the read data |
| bus_rdata | output | 8 | Combinational read data |
| serial_mode | input | 1 | 1: registers control the dividers; 0: pins control them |
| pll_locked | input | 1 | Lock indication from the PLL |
| pin_m | input | 10 | Parallel feedback divider setting |
| pin_na | input | 3 | Parallel post-divider NA setting |
| pin_nb | input | 1 | Parallel post-divider NB setting |
| pin_p | input | 1 | Parallel pre-divider setting |
| div_m | output | 10 | Active feedback divider |
| div_na | output | 3 | Active post-divider NA |
| div_nb | output | 1 | Active post-divider NB |
| div_p | output | 1 | Active pre-divider |

## Verification
A corrupted live divider shows on the `div_*` outputs one cycle after the command that caused it. A corrupted shadow register shows only when it is read back, or when a later load copies it to the outputs. For that reason the tests follow every command with both a divider check and a register readback. Mode switches are checked in the same cycle, because the output multiplexer makes pin changes visible without any register delay.

// File: rtl/pll_cfg_pkg.sv
// Package: shared widths, addresses and types for the divider controller.
// Assumes the high register packs the upper M bits, NA, NB, P and the lock
// bit into exactly one data byte.
package pll_cfg_pkg;
    parameter int DW   = 8;
    parameter int AW   = 8;
    parameter int M_W  = 10;
    parameter int NA_W = 3;
    localparam int M_HI_W  = M_W - DW;
    localparam int CFG_W   = M_W + NA_W + 2;
    localparam int N_CMD   = 4;

    localparam logic [AW-1:0] ADDR_M_LO = 8'h00;
    localparam logic [AW-1:0] ADDR_M_HI = 8'h01;
    localparam logic [AW-1:0] ADDR_CMD  = 8'hF0;

    typedef struct packed {
        logic [M_W-1:0]  m;
        logic [NA_W-1:0] na;
        logic            nb;
        logic            p;
    } div_cfg_t;

    typedef struct packed {
        logic inc;
        logic dec;
        logic load;
        logic get;
    } cmd_t;
endpackage

// File: rtl/cfg_cmd_decode.sv
// Module: cfg_cmd_decode
// Turns a bus write into register write enables and one-hot command pulses.
// Assumes only the low nibble of a command byte matters. It suppresses
// every write while the block is in parallel mode.
module cfg_cmd_decode
    import pll_cfg_pkg::*;
(
    input  logic          clk,
    input  logic          rst_n,
    input  logic          bus_wr,
    input  logic [AW-1:0] bus_addr,
    input  logic [3:0]    cmd_nibble,
    input  logic          serial_mode,
    output logic          wr_lo,
    output logic          wr_hi,
    output cmd_t          cmd
);
    logic             wr_ok;
    logic             cmd_hit;
    logic [N_CMD-1:0] op_vec;

    // qualify writes by mode
    assign wr_ok   = bus_wr && serial_mode;
    assign wr_lo   = wr_ok && (bus_addr == ADDR_M_LO);
    assign wr_hi   = wr_ok && (bus_addr == ADDR_M_HI);
    assign cmd_hit = wr_ok && (bus_addr == ADDR_CMD);

    // one comparator per one-hot opcode
    for (genvar i = 0; i < N_CMD; i++) begin : g_op
        assign op_vec[i] = cmd_hit && (cmd_nibble == 4'(1 << i));
    end

    // map opcode bits to named commands
    always_comb begin
        cmd.inc  = op_vec[0];
        cmd.dec  = op_vec[1];
        cmd.load = op_vec[2];
        cmd.get  = op_vec[3];
    end

    assert_cmd_onehot_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({cmd.inc, cmd.dec, cmd.load, cmd.get}));
    assert_cmd_parallel_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !serial_mode |-> !(wr_lo || wr_hi || cmd.inc || cmd.dec || cmd.load || cmd.get));
endmodule

// File: rtl/cfg_shadow_regs.sv
// Module: cfg_shadow_regs
// Holds the two staged configuration registers. In parallel mode they track
// the pins. In serial mode they take bus writes or a capture of the live
// dividers. Assumes the decoder never asserts capture and a write together.
module cfg_shadow_regs
    import pll_cfg_pkg::*;
(
    input  logic          clk,
    input  logic          rst_n,
    input  logic          serial_mode,
    input  logic          wr_lo,
    input  logic          wr_hi,
    input  logic [DW-1:0] wdata,
    input  logic          get,
    input  logic          step_m,
    input  div_cfg_t      live,
    input  div_cfg_t      pins,
    output div_cfg_t      shadow
);
    // shadow register update
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            shadow <= '0;
        end else if (!serial_mode) begin
            shadow <= pins;
        end else if (get) begin
            shadow <= live;
        end else begin
            if (wr_lo) shadow.m[DW-1:0] <= wdata;
            if (wr_hi) {shadow.m[M_W-1:DW], shadow.na, shadow.nb, shadow.p} <= wdata[DW-1:1];
        end
    end

    assert_lo_write_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (serial_mode && wr_lo) |=> shadow.m[DW-1:0] == $past(wdata));
    assert_step_keeps_regs_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (serial_mode && step_m) |=> $stable(shadow));
    assert_get_copies_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (serial_mode && get) |=> shadow == $past(live));
    assert_parallel_track_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !serial_mode |=> shadow == $past(pins));
endmodule

// File: rtl/div_live_state.sv
// Module: div_live_state
// Holds the live divider state and selects the divider outputs. The pins
// drive the outputs directly in parallel mode, and the live state drives
// them in serial mode. Assumes no range check is wanted: M steps wrap.
module div_live_state
    import pll_cfg_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  logic     serial_mode,
    input  cmd_t     cmd,
    input  div_cfg_t shadow,
    input  div_cfg_t pins,
    output div_cfg_t live_q,
    output div_cfg_t div_out
);
    // live divider update
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            live_q <= '0;
        end else if (!serial_mode) begin
            live_q <= pins;
        end else if (cmd.load) begin
            live_q <= shadow;
        end else if (cmd.inc) begin
            live_q.m <= live_q.m + M_W'(1);
        end else if (cmd.dec) begin
            live_q.m <= live_q.m - M_W'(1);
        end
    end

    // output source select, immediate on mode change
    assign div_out = serial_mode ? live_q : pins;

    assert_inc_wrap_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (serial_mode && cmd.inc) |=> live_q.m == M_W'($past(live_q.m) + 1));
    assert_dec_wrap_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (serial_mode && cmd.dec) |=> live_q.m == M_W'($past(live_q.m) - 1));
    assert_load_copies_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (serial_mode && cmd.load) |=> live_q == $past(shadow));
    assert_idle_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (serial_mode && !(cmd.load || cmd.inc || cmd.dec)) |=> $stable(live_q));
    assert_enter_serial_R10: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $rose(serial_mode)) |-> live_q == $past(pins));
endmodule

// File: rtl/synth_div_ctrl.sv
// Module: synth_div_ctrl (top)
// Register-bus front of the synthesizer divider configuration. It ties the
// decoder, the shadow registers and the live divider state together and
// builds the read multiplexer. Assumes a single-cycle write strobe and
// combinational reads gated by the read strobe.
module synth_div_ctrl
    import pll_cfg_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic [7:0]  bus_addr,
    input  logic [7:0]  bus_wdata,
    input  logic        bus_wr,
    input  logic        bus_rd,
    output logic [7:0]  bus_rdata,
    input  logic        serial_mode,
    input  logic        pll_locked,
    input  logic [9:0]  pin_m,
    input  logic [2:0]  pin_na,
    input  logic        pin_nb,
    input  logic        pin_p,
    output logic [9:0]  div_m,
    output logic [2:0]  div_na,
    output logic        div_nb,
    output logic        div_p
);
    div_cfg_t      pins;
    div_cfg_t      shadow;
    div_cfg_t      live_q;
    div_cfg_t      div_out;
    div_cfg_t      rd_src;
    cmd_t          cmd;
    logic          wr_lo;
    logic          wr_hi;
    logic [DW-1:0] rd_mux;

    // gather pin inputs into one configuration word
    always_comb begin
        pins.m  = pin_m;
        pins.na = pin_na;
        pins.nb = pin_nb;
        pins.p  = pin_p;
    end

    cfg_cmd_decode u_decode (
        .clk         (clk),
        .rst_n       (rst_n),
        .bus_wr      (bus_wr),
        .bus_addr    (bus_addr),
        .cmd_nibble  (bus_wdata[3:0]),
        .serial_mode (serial_mode),
        .wr_lo       (wr_lo),
        .wr_hi       (wr_hi),
        .cmd         (cmd)
    );

    cfg_shadow_regs u_regs (
        .clk         (clk),
        .rst_n       (rst_n),
        .serial_mode (serial_mode),
        .wr_lo       (wr_lo),
        .wr_hi       (wr_hi),
        .wdata       (bus_wdata),
        .get         (cmd.get),
        .step_m      (cmd.inc || cmd.dec),
        .live        (live_q),
        .pins        (pins),
        .shadow      (shadow)
    );

    div_live_state u_live (
        .clk         (clk),
        .rst_n       (rst_n),
        .serial_mode (serial_mode),
        .cmd         (cmd),
        .shadow      (shadow),
        .pins        (pins),
        .live_q      (live_q),
        .div_out     (div_out)
    );

    // read source: pins in parallel mode, shadows in serial mode
    assign rd_src = serial_mode ? shadow : pins;

    // read address decode
    always_comb begin
        unique case (bus_addr)
            ADDR_M_LO: rd_mux = rd_src.m[DW-1:0];
            ADDR_M_HI: rd_mux = {rd_src.m[M_W-1:DW], rd_src.na, rd_src.nb, rd_src.p, pll_locked};
            default:   rd_mux = '0;
        endcase
    end

    // read strobe gating
    assign bus_rdata = bus_rd ? rd_mux : '0;

    // drive divider outputs
    assign div_m  = div_out.m;
    assign div_na = div_out.na;
    assign div_nb = div_out.nb;
    assign div_p  = div_out.p;

    assert_lock_bit_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && bus_addr == ADDR_M_HI) |-> bus_rdata[0] == pll_locked);
    assert_unmapped_zero_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_addr != ADDR_M_LO && bus_addr != ADDR_M_HI) |-> bus_rdata == '0);
    assert_parallel_outputs_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !serial_mode |-> (div_m == pin_m && div_na == pin_na && div_nb == pin_nb && div_p == pin_p));
endmodule

// File: tb/synth_div_ctrl_tb.sv
module synth_div_ctrl_tb;
    logic       clk = 1'b0;
    logic       rst_n;
    logic [7:0] bus_addr, bus_wdata, bus_rdata;
    logic       bus_wr, bus_rd, serial_mode, pll_locked;
    logic [9:0] pin_m, div_m;
    logic [2:0] pin_na, div_na;
    logic       pin_nb, pin_p, div_nb, div_p;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    synth_div_ctrl u_dut (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_rdata(bus_rdata),
        .serial_mode(serial_mode), .pll_locked(pll_locked),
        .pin_m(pin_m), .pin_na(pin_na), .pin_nb(pin_nb), .pin_p(pin_p),
        .div_m(div_m), .div_na(div_na), .div_nb(div_nb), .div_p(div_p)
    );

    // vector: {op[1:0], addr[7:0], value[15:0], req[3:0]}
    // op 0 = write value[7:0]; 1 = read, expect value[7:0]; 2 = expect {m,na,nb,p}
    localparam int NV = 26;
    localparam logic [29:0] VEC [0:NV-1] = '{
        {2'd1, 8'h00, 16'h0000, 4'd1},   // R1 low reg cleared
        {2'd1, 8'h01, 16'h0001, 4'd1},   // R1 high reg cleared, lock=1
        {2'd2, 8'h00, 16'h0000, 4'd1},   // R1 dividers cleared
        {2'd0, 8'h00, 16'h00A5, 4'd2},   // R2 write M low
        {2'd0, 8'h01, 16'h00DA, 4'd3},   // R3 write high, bit0 = 0
        {2'd1, 8'h00, 16'h00A5, 4'd2},   // R2 readback
        {2'd1, 8'h01, 16'h00DB, 4'd3},   // R3 bit0 follows lock
        {2'd2, 8'h00, 16'h0000, 4'd4},   // R4 no effect before load
        {2'd0, 8'hF0, 16'h00F4, 4'd4},   // R4 load, upper nibble junk
        {2'd2, 8'h00, 16'h74AD, 4'd4},   // R4 m=3A5 na=3 nb=0 p=1
        {2'd0, 8'hF0, 16'h0001, 4'd5},   // R5 inc
        {2'd2, 8'h00, 16'h74CD, 4'd5},
        {2'd1, 8'h00, 16'h00A5, 4'd5},   // R5 regs unchanged
        {2'd1, 8'h01, 16'h00DB, 4'd5},
        {2'd0, 8'hF0, 16'h0002, 4'd5},   // R5 dec
        {2'd0, 8'hF0, 16'h0002, 4'd5},
        {2'd2, 8'h00, 16'h748D, 4'd5},
        {2'd0, 8'hF0, 16'h0003, 4'd8},   // R8 two bits set
        {2'd0, 8'hF0, 16'h000C, 4'd8},
        {2'd2, 8'h00, 16'h748D, 4'd8},
        {2'd0, 8'hF0, 16'h0008, 4'd7},   // R7 capture
        {2'd1, 8'h00, 16'h00A4, 4'd7},
        {2'd1, 8'h01, 16'h00DB, 4'd7},
        {2'd2, 8'h00, 16'h748D, 4'd7},
        {2'd1, 8'hF0, 16'h0000, 4'd11},  // R11 command reads zero
        {2'd1, 8'h55, 16'h0000, 4'd11}   // R11 unmapped
    };

    task automatic chk(input int req, input logic [15:0] act, input logic [15:0] exp, input string what);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL R%0d %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
        end
    endtask

    task automatic bus_write(input logic [7:0] a, input logic [7:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic bus_read_chk(input logic [7:0] a, input logic [7:0] exp, input int req);
        @(negedge clk);
        bus_addr = a; bus_rd = 1'b1;
        #1;
        chk(req, {8'h00, bus_rdata}, {8'h00, exp}, "read");
        bus_rd = 1'b0;
    endtask

    function automatic logic [15:0] div_word();
        return {1'b0, div_m, div_na, div_nb, div_p};
    endfunction

    initial begin
        #(200000 * 5);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        rst_n = 1'b0; bus_addr = '0; bus_wdata = '0; bus_wr = 1'b0; bus_rd = 1'b0;
        serial_mode = 1'b1; pll_locked = 1'b1;
        pin_m = 10'h2C3; pin_na = 3'd6; pin_nb = 1'b1; pin_p = 1'b1;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // vector table walk
        for (int i = 0; i < NV; i++) begin
            case (VEC[i][29:28])
                2'd0: bus_write(VEC[i][27:20], VEC[i][11:4]);
                2'd1: bus_read_chk(VEC[i][27:20], VEC[i][11:4], int'(VEC[i][3:0]));
                default: begin
                    @(negedge clk);
                    chk(int'(VEC[i][3:0]), div_word(), VEC[i][19:4], "dividers");
                end
            endcase
        end

        // R6 wrap at both ends
        bus_write(8'h00, 8'hFF);
        bus_write(8'h01, 8'hC0);
        bus_write(8'hF0, 8'h04);
        chk(6, div_word(), 16'h7FE0, "load m=1023");
        bus_write(8'hF0, 8'h01);
        chk(6, div_word(), 16'h0000, "inc wraps to 0");
        bus_write(8'hF0, 8'h02);
        chk(6, div_word(), 16'h7FE0, "dec wraps to 1023");

        // R3 lock low shows in bit 0
        pll_locked = 1'b0;
        bus_read_chk(8'h01, 8'hC0, 3);

        // R11 read strobe low gives zero
        @(negedge clk);
        bus_addr = 8'h00; bus_rd = 1'b0;
        #1 chk(11, {8'h00, bus_rdata}, 16'h0000, "rd low");

        // R10 serial to parallel: outputs follow pins at once
        @(negedge clk);
        pin_m = 10'h155; pin_na = 3'd5; pin_nb = 1'b1; pin_p = 1'b0;
        serial_mode = 1'b0;
        #1 chk(10, div_word(), 16'h2AB6, "enter parallel");
        // R9 reads return pins, writes ignored
        bus_read_chk(8'h00, 8'h55, 9);
        bus_read_chk(8'h01, 8'h6C, 9);
        bus_write(8'hF0, 8'h01);
        chk(9, div_word(), 16'h2AB6, "inc ignored");
        bus_write(8'h01, 8'hFF);
        bus_read_chk(8'h01, 8'h6C, 9);
        @(negedge clk);
        pin_m = 10'h0F0;
        #1 chk(9, div_word(), 16'h1E16, "pins followed");

        // R10 parallel to serial keeps last configuration
        @(negedge clk);
        serial_mode = 1'b1;
        @(negedge clk);
        pin_m = 10'h3FF; pin_na = 3'd0; pin_nb = 1'b0; pin_p = 1'b1;
        #1 chk(10, div_word(), 16'h1E16, "held after switch");
        bus_read_chk(8'h00, 8'hF0, 10);
        bus_write(8'hF0, 8'h01);
        chk(10, div_word(), 16'h1E36, "serial control resumed");

        // R1 reset mid-run clears everything
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        chk(1, div_word(), 16'h0000, "reset dividers");
        bus_read_chk(8'h00, 8'h00, 1);
        bus_read_chk(8'h01, 8'h00, 1);

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule